// File: doc/BRIEF.md
# Cycle Timer with Shared Watchdog Prescaler

This block holds an 8-bit timer/counter and one programmable prescaler. Either the timer or a watchdog owns the prescaler at any one time. An 8-bit option register, loaded from the working register, selects four things: what the timer counts (instruction-cycle ticks or edges on an external clock pin), which pin edge is counted, which unit owns the prescaler, and a 3-bit rate code. The unit that does not own the prescaler runs undivided.

The timer clock pin passes through a two-flop synchroniser before its edges are detected. While the timer counts the pin, the block tells the I/O port to hold that pin as an input. A write to the timer loads a new count. If the prescaler belongs to the timer, the same write empties the prescaler. The two top option bits are not used inside the block; they go straight out to the port logic as the wake-on-change and pull-up disable controls.

Top module: `cycle_timer_wdog`

## Requirements
- R1: After reset, the timer reads 00h and the watchdog tick is low. Every option bit reads 1, so wakeDisable, pullDisable and pinForceInput are all 1.
- R2: A cycle with optWrEn high loads optWrData into the option register; it takes effect from the next cycle. Field positions: bit 7 drives wakeDisable, bit 6 drives pullDisable, bit 5 selects the source (1 = pin), bit 4 selects the edge (1 = falling), bit 3 selects the owner (1 = watchdog), and bits 2:0 are the rate code.
- R3: With source = 0, the timer counts cycleTick pulses.
- R4: With source = 1 and edge = 0, the timer counts rising edges of extPin. The count changes on the third rising clock edge that samples the new pin level.
- R5: With source = 1 and edge = 1, the timer counts falling edges of extPin, with the same latency as R4.
- R6: With owner = 0, the timer advances once per 2^(code+1) source events, so code 000 gives 1:2 and code 111 gives 1:256. In this mode the watchdog tick follows every base tick.
- R7: With owner = 1, wdogTimeoutTick pulses once per 2^code base ticks, so code 000 gives 1:1 and code 111 gives 1:128. In this mode the timer counts every source event. The tick is a one-cycle pulse in the cycle after the base tick that completes the ratio.
- R8: The timer wraps from FFh to 00h.
- R9: cntWrEn loads cntWrData into the timer. The load takes precedence over an increment in the same cycle. When owner = 0, the load also clears the prescaler, so the next increment needs a full ratio of events.
- R10: pinForceInput equals the source bit.
- R11: With source = 0, changes on extPin have no effect on the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cycleTick | input | 1 | Instruction-cycle tick, one clock wide |
| extPin | input | 1 | External timer clock pin, asynchronous |
| wdogBaseTick | input | 1 | Watchdog base tick, one clock wide |
| optWrEn | input | 1 | Load the option register |
| optWrData | input | 8 | New option value from the working register |
| cntWrEn | input | 1 | Load the timer |
| cntWrData | input | TMR_W | New timer value |
| timerCount | output | TMR_W | Current timer count |
| wdogTimeoutTick | output | 1 | Prescaled watchdog tick, one clock wide |
| pinForceInput | output | 1 | Forces the timer pin's port direction to input |
| wakeDisable | output | 1 | Option bit 7, to the port logic |
| pullDisable | output | 1 | Option bit 6, to the port logic |

## Verification
The bench targets four corner cases. First, the one-step shift in the ratio table between the two owners: a design that used the timer's table for the watchdog would show 1:2 where 1:1 is expected and half the tick count at code 3. Second, the 1:256 end of the table: the bench checks the count one event before the rollover and again at it, which catches a shortened mask. Third, a timer load that lands on the same cycle as a prescaler overflow: a design that does not clear the prescaler, or lets the increment win, shows 41h one event early or right away. Fourth, the exact pin latency and edge polarity: a synchroniser with the wrong depth, or a swapped edge select, moves or drops counts while extPin toggles, and a design that lets the pin leak into internal-source mode counts while it should stay still.

// File: rtl/cycle_timer_pkg.sv
package cycle_timer_pkg;

  localparam int OPT_W  = 8;
  localparam int RATE_W = 3;

  // Option register layout; bit order matches the working-register data
  typedef struct packed {
    logic              wakeDis;
    logic              pullDis;
    logic              extSrc;
    logic              fallEdge;
    logic              preToWdog;
    logic [RATE_W-1:0] rate;
  } optFields_t;

  // Strobes from control to datapath, valid for the current cycle
  typedef struct packed {
    logic              timerEvent;
    logic              wdogEvent;
    logic              preToWdog;
    logic              preClear;
    logic              cntLoad;
    logic [RATE_W-1:0] rate;
  } ctlStrobes_t;

endpackage

// File: rtl/cycle_timer_ctrl.sv
module cycle_timer_ctrl
  import cycle_timer_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cycleTick,
  input  logic                 extPin,
  input  logic                 wdogBaseTick,
  input  logic                 optWrEn,
  input  logic [OPT_W-1:0]     optWrData,
  input  logic                 cntWrEn,
  output optFields_t           optQ,
  output ctlStrobes_t          strobes
);

  logic [SYNC_STAGES:0] syncQ;
  logic newerLvl;
  logic olderLvl;
  logic riseSeen;
  logic fallSeen;
  logic pinEvent;

  // Write-only option register, all ones out of reset
  always_ff @(posedge clk) begin
    if (!rstN) begin
      optQ <= '1;
    end else if (optWrEn) begin
      optQ <= optFields_t'(optWrData);
    end
  end

  // Synchroniser chain plus one extra stage for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ <= '0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-1:0], extPin};
    end
  end

  assign newerLvl = syncQ[SYNC_STAGES-1];
  assign olderLvl = syncQ[SYNC_STAGES];
  assign riseSeen = newerLvl & ~olderLvl;
  assign fallSeen = ~newerLvl & olderLvl;
  assign pinEvent = optQ.fallEdge ? fallSeen : riseSeen;

  always_comb begin
    strobes            = '0;
    strobes.timerEvent = optQ.extSrc ? pinEvent : cycleTick;
    strobes.wdogEvent  = wdogBaseTick;
    strobes.preToWdog  = optQ.preToWdog;
    strobes.preClear   = cntWrEn & ~optQ.preToWdog;
    strobes.cntLoad    = cntWrEn;
    strobes.rate       = optQ.rate;
  end

endmodule

// File: rtl/cycle_timer_dp.sv
module cycle_timer_dp
  import cycle_timer_pkg::*;
#(
  parameter int TMR_W   = 8,
  parameter int PRESC_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [TMR_W-1:0]  cntWrData,
  output logic [TMR_W-1:0]  timerCount,
  output logic              wdogTick
);

  localparam int SHIFT_W = RATE_W + 1;

  logic [SHIFT_W-1:0] rateShift;
  logic [PRESC_W-1:0] rateMask;
  logic [PRESC_W-1:0] preCnt;
  logic preEvent;
  logic preHit;
  logic timerInc;
  logic wdogNext;

  // The timer's table sits one step above the watchdog's
  assign rateShift = {1'b0, strobes.rate} + (strobes.preToWdog ? SHIFT_W'(0) : SHIFT_W'(1));

  // Thermometer mask: the low rateShift bits set
  for (genvar g = 0; g < PRESC_W; g++) begin : g_mask
    assign rateMask[g] = (int'(rateShift) > g);
  end

  assign preEvent = strobes.preToWdog ? strobes.wdogEvent : strobes.timerEvent;
  assign preHit   = preEvent && ((preCnt & rateMask) == rateMask);
  assign timerInc = strobes.preToWdog ? strobes.timerEvent : preHit;
  assign wdogNext = strobes.preToWdog ? preHit : strobes.wdogEvent;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (strobes.preClear) begin
      preCnt <= '0;
    end else if (preEvent) begin
      preCnt <= preCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timerCount <= '0;
    end else if (strobes.cntLoad) begin
      timerCount <= cntWrData;
    end else if (timerInc) begin
      timerCount <= timerCount + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wdogTick <= 1'b0;
    end else begin
      wdogTick <= wdogNext;
    end
  end

endmodule

// File: rtl/cycle_timer_wdog.sv
module cycle_timer_wdog
  import cycle_timer_pkg::*;
#(
  parameter int TMR_W       = 8,
  parameter int PRESC_W     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cycleTick,
  input  logic              extPin,
  input  logic              wdogBaseTick,
  input  logic              optWrEn,
  input  logic [7:0]        optWrData,
  input  logic              cntWrEn,
  input  logic [TMR_W-1:0]  cntWrData,
  output logic [TMR_W-1:0]  timerCount,
  output logic              wdogTimeoutTick,
  output logic              pinForceInput,
  output logic              wakeDisable,
  output logic              pullDisable
);

  optFields_t  optQ;
  ctlStrobes_t strobes;

  cycle_timer_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cycleTick    (cycleTick),
    .extPin       (extPin),
    .wdogBaseTick (wdogBaseTick),
    .optWrEn      (optWrEn),
    .optWrData    (optWrData),
    .cntWrEn      (cntWrEn),
    .optQ         (optQ),
    .strobes      (strobes)
  );

  cycle_timer_dp #(.TMR_W(TMR_W), .PRESC_W(PRESC_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .cntWrData  (cntWrData),
    .timerCount (timerCount),
    .wdogTick   (wdogTimeoutTick)
  );

  assign pinForceInput = optQ.extSrc;
  assign wakeDisable   = optQ.wakeDis;
  assign pullDisable   = optQ.pullDis;

endmodule

// File: rtl/cycle_timer_wdog_chk.sv
module cycle_timer_wdog_chk #(
  parameter int TMR_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             cycleTick,
  input logic             cntWrEn,
  input logic [TMR_W-1:0] cntWrData,
  input logic [TMR_W-1:0] timerCount,
  input logic             wdogBaseTick,
  input logic             wdogTimeoutTick,
  input logic             optWrEn,
  input logic [2:0]       optCtlBits,
  input logic             wakeDisable,
  input logic             pullDisable,
  input logic             pinForceInput
);

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (timerCount == '0) && !wdogTimeoutTick && wakeDisable && pullDisable && pinForceInput);

  assert_opt_fields_R2: assert property (@(posedge clk) disable iff (!rstN)
    $past(optWrEn) |-> {wakeDisable, pullDisable, pinForceInput} == $past(optCtlBits));

  assert_single_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(cntWrEn) && (timerCount != $past(timerCount))) |-> timerCount == TMR_W'($past(timerCount) + 1'b1));

  assert_tick_needs_base_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$past(wdogBaseTick) |-> !wdogTimeoutTick);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    (($past(timerCount) == {TMR_W{1'b1}}) && !$past(cntWrEn) && (timerCount != $past(timerCount))) |-> timerCount == '0);

  assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(cntWrEn) |-> timerCount == $past(cntWrData));

  assert_pin_ignored_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(pinForceInput) && !$past(optWrEn) && !$past(cntWrEn) && !$past(cycleTick)) |-> $stable(timerCount));

endmodule

bind cycle_timer_wdog cycle_timer_wdog_chk #(.TMR_W(TMR_W)) u_chk (
  .clk             (clk),
  .rstN            (rstN),
  .cycleTick       (cycleTick),
  .cntWrEn         (cntWrEn),
  .cntWrData       (cntWrData),
  .timerCount      (timerCount),
  .wdogBaseTick    (wdogBaseTick),
  .wdogTimeoutTick (wdogTimeoutTick),
  .optWrEn         (optWrEn),
  .optCtlBits      (optWrData[7:5]),
  .wakeDisable     (wakeDisable),
  .pullDisable     (pullDisable),
  .pinForceInput   (pinForceInput)
);

// File: tb/sim_cycle_timer_wdog.sv
`timescale 1ns/1ps
module sim_cycle_timer_wdog;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cycleTick = 1'b0;
  logic extPin = 1'b0;
  logic wdogBaseTick = 1'b0;
  logic optWrEn = 1'b0;
  logic [7:0] optWrData = '0;
  logic cntWrEn = 1'b0;
  logic [7:0] cntWrData = '0;
  logic [7:0] timerCount;
  logic wdogTimeoutTick;
  logic pinForceInput;
  logic wakeDisable;
  logic pullDisable;

  int checks = 0;
  int fails = 0;
  int wdCnt = 0;
  int wdStart = 0;
  bit finished = 0;
  string curReq = "R1";

  // Reference model state
  logic [7:0] mOpt;
  int mS1, mS2, mS3, mPre, mTmr;
  logic mWd;

  always #4 clk = ~clk;

  cycle_timer_wdog u0 (
    .clk(clk), .rstN(rstN), .cycleTick(cycleTick), .extPin(extPin),
    .wdogBaseTick(wdogBaseTick), .optWrEn(optWrEn), .optWrData(optWrData),
    .cntWrEn(cntWrEn), .cntWrData(cntWrData), .timerCount(timerCount),
    .wdogTimeoutTick(wdogTimeoutTick), .pinForceInput(pinForceInput),
    .wakeDisable(wakeDisable), .pullDisable(pullDisable)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      mOpt = 8'hFF; mS1 = 0; mS2 = 0; mS3 = 0; mPre = 0; mTmr = 0; mWd = 1'b0;
    end else begin
      bit rise, fall, psa, src, ev, hit;
      int ratio;
      rise = (mS2 == 1) && (mS3 == 0);
      fall = (mS2 == 0) && (mS3 == 1);
      mS3 = mS2; mS2 = mS1; mS1 = int'(extPin);
      psa = mOpt[3];
      ratio = psa ? (1 << mOpt[2:0]) : (2 << mOpt[2:0]);
      src = mOpt[5] ? (mOpt[4] ? fall : rise) : cycleTick;
      ev = psa ? wdogBaseTick : src;
      hit = ev && (((mPre + 1) % ratio) == 0);
      if (cntWrEn && !psa) mPre = 0;
      else if (ev) mPre = (mPre + 1) % 256;
      if (cntWrEn) mTmr = int'(cntWrData);
      else if (psa ? src : hit) mTmr = (mTmr + 1) % 256;
      mWd = psa ? hit : wdogBaseTick;
      if (optWrEn) mOpt = optWrData;
    end
  end

  always @(posedge clk) begin
    if (rstN && wdogTimeoutTick) wdCnt++;
  end

  task automatic check(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Compare against the model on every clock
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check({curReq, " timer"}, int'(timerCount) == mTmr, int'(timerCount), mTmr);
      check({curReq, " wdog"}, wdogTimeoutTick == mWd, int'(wdogTimeoutTick), int'(mWd));
      check({curReq, " optOut"}, {wakeDisable, pullDisable, pinForceInput} == mOpt[7:5],
            int'({wakeDisable, pullDisable, pinForceInput}), int'(mOpt[7:5]));
    end
  end

  task automatic cyc(input logic ct, input logic wb, input logic pin);
    cycleTick = ct; wdogBaseTick = wb; extPin = pin;
    @(negedge clk);
  endtask

  task automatic writeOpt(input logic [7:0] v);
    optWrEn = 1'b1; optWrData = v; cycleTick = 1'b0; wdogBaseTick = 1'b0;
    @(negedge clk);
    optWrEn = 1'b0;
  endtask

  task automatic writeCnt(input logic [7:0] v, input logic ct);
    cntWrEn = 1'b1; cntWrData = v; cycleTick = ct; wdogBaseTick = 1'b0;
    @(negedge clk);
    cntWrEn = 1'b0; cycleTick = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      checks++;
      $display("FAIL watchdog expired actual 1 expected 0");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", timerCount == 8'h00, int'(timerCount), 0);
    check("R1", wdogTimeoutTick == 1'b0, int'(wdogTimeoutTick), 0);
    check("R1", {wakeDisable, pullDisable, pinForceInput} == 3'b111,
          int'({wakeDisable, pullDisable, pinForceInput}), 7);

    // R2 option fields
    curReq = "R2";
    writeOpt(8'b0011_1000);
    check("R2", {wakeDisable, pullDisable, pinForceInput} == 3'b001,
          int'({wakeDisable, pullDisable, pinForceInput}), 1);
    writeOpt(8'b1100_1000);
    check("R10", pinForceInput == 1'b0, int'(pinForceInput), 0);

    // R3, R11, R7 at code 0: internal source, watchdog owns prescaler
    curReq = "R3";
    writeCnt(8'h00, 1'b0);
    wdStart = wdCnt;
    for (int k = 0; k < 20; k++) cyc(1'b1, (k % 3) == 0, k[0]);
    cyc(1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0);
    check("R3", timerCount == 8'd20, int'(timerCount), 20);
    check("R7", (wdCnt - wdStart) == 7, wdCnt - wdStart, 7);
    curReq = "R11";
    for (int k = 0; k < 8; k++) cyc(1'b0, 1'b0, k < 4);
    check("R11", timerCount == 8'd20, int'(timerCount), 20);

    // R6: timer owns prescaler, 1:8 then 1:256
    curReq = "R6";
    writeOpt(8'b1100_0010);
    writeCnt(8'h00, 1'b0);
    wdStart = wdCnt;
    for (int k = 0; k < 64; k++) cyc(1'b1, k < 5, 1'b0);
    cyc(1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0);
    check("R6", timerCount == 8'd8, int'(timerCount), 8);
    check("R6", (wdCnt - wdStart) == 5, wdCnt - wdStart, 5);
    writeOpt(8'b1100_0111);
    writeCnt(8'h00, 1'b0);
    for (int k = 0; k < 511; k++) cyc(1'b1, 1'b0, 1'b0);
    check("R6", timerCount == 8'd1, int'(timerCount), 1);
    cyc(1'b1, 1'b0, 1'b0);
    check("R6", timerCount == 8'd2, int'(timerCount), 2);

    // R7: watchdog owns prescaler at code 3 (1:8), timer 1:1
    curReq = "R7";
    writeCnt(8'h00, 1'b0);
    writeOpt(8'b1100_1011);
    writeCnt(8'h10, 1'b0);
    wdStart = wdCnt;
    for (int k = 0; k < 64; k++) cyc(k < 10, 1'b1, 1'b0);
    cyc(1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0);
    check("R7", (wdCnt - wdStart) == 8, wdCnt - wdStart, 8);
    check("R7", timerCount == 8'h1A, int'(timerCount), 'h1A);

    // R4: rising pin edges, latency and count
    curReq = "R4";
    writeOpt(8'b1110_1000);
    check("R10", pinForceInput == 1'b1, int'(pinForceInput), 1);
    writeCnt(8'h00, 1'b0);
    cyc(1'b1, 1'b0, 1'b1);
    cyc(1'b1, 1'b0, 1'b1);
    check("R4", timerCount == 8'd0, int'(timerCount), 0);
    cyc(1'b1, 1'b0, 1'b1);
    check("R4", timerCount == 8'd1, int'(timerCount), 1);
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < 3; k++) cyc(1'b0, 1'b0, 1'b0);
      for (int k = 0; k < 3; k++) cyc(1'b0, 1'b0, 1'b1);
    end
    for (int k = 0; k < 3; k++) cyc(1'b0, 1'b0, 1'b0);
    check("R4", timerCount == 8'd5, int'(timerCount), 5);

    // R5: falling pin edges
    curReq = "R5";
    writeOpt(8'b1111_1000);
    writeCnt(8'h00, 1'b0);
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < 3; k++) cyc(1'b0, 1'b0, 1'b1);
      for (int k = 0; k < 3; k++) cyc(1'b0, 1'b0, 1'b0);
    end
    cyc(1'b0, 1'b0, 1'b0);
    check("R5", timerCount == 8'd4, int'(timerCount), 4);

    // R8: wrap
    curReq = "R8";
    writeOpt(8'b1100_1000);
    writeCnt(8'hFE, 1'b0);
    cyc(1'b1, 1'b0, 1'b0);
    check("R8", timerCount == 8'hFF, int'(timerCount), 'hFF);
    cyc(1'b1, 1'b0, 1'b0);
    check("R8", timerCount == 8'h00, int'(timerCount), 0);
    cyc(1'b1, 1'b0, 1'b0);
    check("R8", timerCount == 8'h01, int'(timerCount), 1);

    // R9: load beats increment and clears prescaler (1:4)
    curReq = "R9";
    writeOpt(8'b1100_0001);
    writeCnt(8'h00, 1'b0);
    for (int k = 0; k < 3; k++) cyc(1'b1, 1'b0, 1'b0);
    check("R9", timerCount == 8'h00, int'(timerCount), 0);
    writeCnt(8'h40, 1'b1);
    check("R9", timerCount == 8'h40, int'(timerCount), 'h40);
    for (int k = 0; k < 3; k++) cyc(1'b1, 1'b0, 1'b0);
    check("R9", timerCount == 8'h40, int'(timerCount), 'h40);
    cyc(1'b1, 1'b0, 1'b0);
    check("R9", timerCount == 8'h41, int'(timerCount), 'h41);
    cyc(1'b0, 1'b0, 1'b0);

    if (!finished) begin
      finished = 1;
      summary();
      $finish;
    end
  end

endmodule